// File: doc/BRIEF.md
# Gap-Interval Write Decoder

This block turns the field-interruption pattern a reader uses to send data into a stream of decoded bits. It runs on the field clock recovered from the coil. Its input is a one-cycle strobe that marks each detected field gap and is already synchronised to that clock. After reset it first spends a fixed configuration-load window of 256 field clocks. It then waits for a gap. That first gap is the start gap and opens a write session. During the session it counts the field clocks between successive gaps and classifies each interval against fixed acceptance windows. The result is a data 0, a data 1 or an invalid interval. Between the 0 band and the 1 band lies a dead band that is treated as invalid.

A write session ends when no gap arrives for more than 64 field clocks. The block then leaves write mode and pulses an end-of-write strobe. Next to that strobe it shows a sticky flag that records whether any interval in the session was invalid. While a session is open, the load-damping output is forced on so the reader can see gaps more easily. Outside a session the damping output follows the read modulator data. Frame parsing (opcode, password, address) and memory programming belong to the logic downstream.

The controller has three states. `ST_LOAD` is the configuration window. `ST_READ` is idle and waits for a start gap. `ST_WRITE` is the open session. There are four transitions. LOAD→LOAD happens on a gap, which restarts the window. LOAD→READ happens once the window completes. READ→WRITE happens on a gap. WRITE→READ happens on the gap-free timeout.

Top module: `gap_write_decoder`

## Requirements
- R1: While reset is held and right after it, `wr_mode_o`, `bit_vld_o`, `wr_done_o` and `wr_fail_o` are all 0 and the block is in the configuration window.
- R2: The configuration window is 256 consecutive gap-free clocks after reset. A gap during the window restarts it from zero and does not open a write session. A gap on the 256th clock of a window is still inside the window.
- R3: The first gap after the window completes is the start gap. From the clock edge that samples it, `wr_mode_o` is 1 and `wr_fail_o` is cleared to 0. The start gap itself yields no bit.
- R4: `damp_o` is 1 whenever `wr_mode_o` is 1. Otherwise `damp_o` equals `mod_i`.
- R5: Within a session, a gap that arrives K clocks after the previous gap with 16 ≤ K ≤ 31 gives `bit_vld_o`=1 and `bit_val_o`=0 for one cycle. This output appears at the edge that samples the gap.
- R6: Within a session, an interval with 48 ≤ K ≤ 64 gives `bit_vld_o`=1 and `bit_val_o`=1 for one cycle at the same edge.
- R7: An interval with K < 16 or 32 ≤ K ≤ 47 gives no bit and sets `wr_fail_o`. The session stays open and later valid intervals still decode.
- R8: If 65 clocks pass after the last gap of a session, `wr_mode_o` falls and `wr_done_o` pulses for exactly one cycle. A gap on that 65th clock is ignored.
- R9: `wr_fail_o` keeps its value through the end of a session and while `wr_done_o` is high. Only the next start gap clears it.
- R10: The interval counter saturates at 65 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered field clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gap_i | input | 1 | One-cycle strobe per detected field gap |
| mod_i | input | 1 | Read modulator damping request |
| wr_mode_o | output | 1 | Write session open |
| damp_o | output | 1 | Load-damping enable |
| bit_vld_o | output | 1 | Decoded bit strobe |
| bit_val_o | output | 1 | Decoded bit value |
| wr_done_o | output | 1 | End-of-write strobe |
| wr_fail_o | output | 1 | Sticky invalid-interval flag |

## Verification
The assertions assume that `gap_i` is a single-cycle strobe per gap and is already synchronous to `clk`. This is why a decoded bit is only ever tied to one sampled gap edge. The stimulus keeps to this assumption: every gap is raised for exactly one clock between falling edges. Intervals are placed by counting clocks from the previous gap, so each boundary of the 0 band, the dead band, the 1 band and the timeout is hit on its exact clock.

// File: rtl/gwd_pkg.sv
package gwd_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } gwd_state_e;

    typedef enum logic [1:0] {
        IV_FAIL = 2'd0,
        IV_ZERO = 2'd1,
        IV_ONE  = 2'd2
    } gwd_ivl_e;
endpackage

// File: rtl/gwd_interval_ctr.sv
module gwd_interval_ctr #(
    parameter int LIMIT = 65,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;

    // a restart loads 1 so the count equals the clock distance at the next gap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= CW'(1);
        else if (en_i && cnt_q != CW'(LIMIT))
            cnt_q <= cnt_q + CW'(1);
    end

    assign cnt_o = cnt_q;

    a_r10_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(LIMIT) && !clr_i) |=> (cnt_q == CW'(LIMIT)));

    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/gwd_classify.sv
module gwd_classify
    import gwd_pkg::*;
#(
    parameter int ZERO_MIN = 16,
    parameter int DEAD_MIN = 32,
    parameter int ONE_MIN  = 48,
    parameter int ONE_MAX  = 64,
    localparam int CW = $clog2(ONE_MAX + 2)
) (
    input  logic [CW-1:0] cnt_i,
    output gwd_ivl_e      ivl_o
);
    always_comb begin
        if (cnt_i >= CW'(ZERO_MIN) && cnt_i < CW'(DEAD_MIN))
            ivl_o = IV_ZERO;
        else if (cnt_i >= CW'(ONE_MIN) && cnt_i <= CW'(ONE_MAX))
            ivl_o = IV_ONE;
        else
            ivl_o = IV_FAIL;
    end
endmodule

// File: rtl/gap_write_decoder.sv
module gap_write_decoder
    import gwd_pkg::*;
#(
    parameter int CFG_CLKS = 256,
    parameter int ZERO_MIN = 16,
    parameter int DEAD_MIN = 32,
    parameter int ONE_MIN  = 48,
    parameter int ONE_MAX  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_i,
    input  logic mod_i,
    output logic wr_mode_o,
    output logic damp_o,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic wr_done_o,
    output logic wr_fail_o
);
    localparam int LIMIT = ONE_MAX + 1;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam int LW    = $clog2(CFG_CLKS);

    gwd_state_e    state_q, state_d;
    logic [LW-1:0] ld_cnt_q;
    logic [CW-1:0] ivl_cnt;
    gwd_ivl_e      ivl;
    logic          in_write, timeout, start_gap, data_gap, ld_last;
    logic          bit_vld_q, bit_val_q, done_q, fail_q;

    assign in_write  = (state_q == ST_WRITE);
    assign timeout   = in_write && (ivl_cnt == CW'(LIMIT));
    assign start_gap = (state_q == ST_READ) && gap_i;
    assign data_gap  = in_write && !timeout && gap_i;
    assign ld_last   = (ld_cnt_q == LW'(CFG_CLKS - 1));

    gwd_interval_ctr #(.LIMIT(LIMIT)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_gap || data_gap),
        .en_i  (in_write),
        .cnt_o (ivl_cnt)
    );

    gwd_classify #(
        .ZERO_MIN (ZERO_MIN),
        .DEAD_MIN (DEAD_MIN),
        .ONE_MIN  (ONE_MIN),
        .ONE_MAX  (ONE_MAX)
    ) u_cls (
        .cnt_i (ivl_cnt),
        .ivl_o (ivl)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (!gap_i && ld_last) state_d = ST_READ;
            ST_READ:  if (gap_i)             state_d = ST_WRITE;
            ST_WRITE: if (timeout)           state_d = ST_READ;
            default:                         state_d = ST_LOAD;
        endcase
    end

    // state register and configuration window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_LOAD;
            ld_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_LOAD || gap_i)
                ld_cnt_q <= '0;
            else if (!ld_last)
                ld_cnt_q <= ld_cnt_q + LW'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_vld_q <= 1'b0;
            bit_val_q <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            bit_vld_q <= data_gap && (ivl != IV_FAIL);
            bit_val_q <= data_gap && (ivl == IV_ONE);
            done_q    <= timeout;
            if (start_gap)
                fail_q <= 1'b0;
            else if (data_gap && ivl == IV_FAIL)
                fail_q <= 1'b1;
        end
    end

    assign wr_mode_o = in_write;
    assign damp_o    = in_write || mod_i;
    assign bit_vld_o = bit_vld_q;
    assign bit_val_o = bit_val_q;
    assign wr_done_o = done_q;
    assign wr_fail_o = fail_q;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    a_r8_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (!wr_mode_o && $past(wr_mode_o)));

    a_r5_bit_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_q |-> $past(wr_mode_o));

    a_r3_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_mode_o) |-> !fail_q);

    a_r4_damp_forced: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode_o |-> damp_o);

    a_r9_fail_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !start_gap) |=> fail_q);

    a_r2_no_write_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> !wr_mode_o);

    a_r7_no_bit_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> !bit_vld_q);
endmodule

// File: tb/sim_gap_write_decoder.sv
module sim_gap_write_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gap = 1'b0;
    logic mod = 1'b0;
    logic wr_mode, damp, bit_vld, bit_val, wr_done, wr_fail;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    gap_write_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_i     (gap),
        .mod_i     (mod),
        .wr_mode_o (wr_mode),
        .damp_o    (damp),
        .bit_vld_o (bit_vld),
        .bit_val_o (bit_val),
        .wr_done_o (wr_done),
        .wr_fail_o (wr_fail)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse();
        gap = 1'b1;
        @(negedge clk);
        gap = 1'b0;
    endtask

    // next gap lands exactly k clocks after the previous one
    task automatic send(input int k);
        idle(k - 1);
        pulse();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        check("R1 wr_mode in reset", wr_mode, 0);
        check("R1 bit_vld in reset", bit_vld, 0);
        check("R1 wr_done in reset", wr_done, 0);
        check("R1 wr_fail in reset", wr_fail, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        idle(100);
        pulse();
        check("R2 gap mid window", wr_mode, 0);
        idle(255);
        pulse();
        check("R2 gap on 256th clock", wr_mode, 0);
        idle(256);
        check("R4 damp follows mod idle", damp, 0);
        mod = 1'b1;
        #1;
        check("R4 damp follows mod high", damp, 1);
        mod = 1'b0;
        pulse();
        check("R3 start gap opens session", wr_mode, 1);
        check("R3 start gap gives no bit", bit_vld, 0);
        check("R4 damp forced in session", damp, 1);
    endtask

    task automatic t_bits();
        send(24); check("R5 bit 24 valid", bit_vld, 1); check("R5 bit 24 value", bit_val, 0);
        send(16); check("R5 bit 16 valid", bit_vld, 1); check("R5 bit 16 value", bit_val, 0);
        send(31); check("R5 bit 31 valid", bit_vld, 1); check("R5 bit 31 value", bit_val, 0);
        send(56); check("R6 bit 56 valid", bit_vld, 1); check("R6 bit 56 value", bit_val, 1);
        send(48); check("R6 bit 48 valid", bit_vld, 1); check("R6 bit 48 value", bit_val, 1);
        send(64); check("R6 bit 64 valid", bit_vld, 1); check("R6 bit 64 value", bit_val, 1);
        check("R7 no fail yet", wr_fail, 0);
    endtask

    task automatic t_fails();
        send(15); check("R7 interval 15 no bit", bit_vld, 0); check("R7 interval 15 flag", wr_fail, 1);
        send(32); check("R7 interval 32 no bit", bit_vld, 0);
        send(47); check("R7 interval 47 no bit", bit_vld, 0);
        send(24); check("R7 decode continues", bit_vld, 1); check("R7 decode value", bit_val, 0);
        check("R9 flag held", wr_fail, 1);
    endtask

    task automatic t_timeout();
        idle(64);
        check("R8 still open at 64", wr_mode, 1);
        check("R8 no done at 64", wr_done, 0);
        idle(1);
        check("R8 closed at 65", wr_mode, 0);
        check("R8 done strobe", wr_done, 1);
        check("R9 flag with done", wr_fail, 1);
        idle(1);
        check("R8 done one cycle", wr_done, 0);
        check("R9 flag after session", wr_fail, 1);
        pulse();
        check("R9 flag cleared by start", wr_fail, 0);
        check("R3 reopened", wr_mode, 1);
        send(20); check("R5 bit 20 value", bit_val, 0); check("R5 bit 20 valid", bit_vld, 1);
        send(65);
        check("R8 gap at 65 ignored bit", bit_vld, 0);
        check("R8 gap at 65 closes", wr_mode, 0);
        check("R8 gap at 65 done", wr_done, 1);
        check("R9 clean session flag", wr_fail, 0);
        idle(2);
        pulse();
        check("R3 next start gap", wr_mode, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_bits();
        t_fails();
        t_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule